// File: doc/BRIEF.md
# Static Memory Strobe Timing Generator

This block drives one chip-select of an asynchronous external memory port, such as NAND, NOR or pseudo-static RAM. A host issues a request with an address, write data and a direction, and holds it until a one-clock ready pulse comes back. The block then plays a single access onto the memory pins. The access lasts a programmed number of controller clocks. Within that length, the active-low chip select and the active-low read or write strobe each rise and fall according to their own setup and pulse counts. Reads and writes each have their own timing set.

Timings are taken from two configuration buses, one for reads and one for writes. Each bus packs five CW-bit fields: bits [CW-1:0] hold the strobe setup, [2CW-1:CW] the chip-select setup, [3CW-1:2CW] the strobe pulse, [4CW-1:3CW] the chip-select pulse and [5CW-1:4CW] the total cycle count. When a request is accepted, the block snapshots the bus for that direction, together with the float count and the read-capture mode. After a read, a programmable number of float cycles keeps the bus idle before the next access may begin.

Top module: `sm_strobe_gen`

## Requirements
- R1: During and after reset, ncs_o, nrd_o and nwe_o are high, data_oe_o and ready_o are low, and rdata_o is zero.
- R2: A request is accepted on a clock edge where the block is idle and req_i is high. The next clock is access cycle 0. In access cycle k, ncs_o is low exactly when cs_setup <= k < cs_setup + cs_pulse.
- R3: In access cycle k, the strobe for the access direction (nrd_o for reads, nwe_o for writes) is low exactly when strobe_setup <= k < strobe_setup + strobe_pulse. The other strobe stays high.
- R4: An access lasts exactly `cycle` clocks, taken from the bus of its own direction. A cycle count of 0 behaves as 1.
- R5: A setup count of 0 puts its signal low in access cycle 0.
- R6: A pulse that reaches past the cycle count is cut at the last access cycle. Nothing is asserted after it.
- R7: ready_o is high for exactly one clock, in the last access cycle.
- R8: Read data is taken from data_i on the clock edge that ends the last low cycle of nrd_o when cfg_rd_by_strb_i = 1, or of ncs_o when it is 0. If that signal never goes low in the access, data_i is taken at the edge that ends the access. The captured value then holds on rdata_o.
- R9: For a write, data_oe_o is high and wdata_o carries the request's write data in every access cycle. data_oe_o is low in the clock after the access. For a read, data_oe_o stays low.
- R10: After a read with float count F, the next access cycle 0 comes no sooner than F + 2 clocks after the read's last cycle. No strobe or data enable is active during the float clocks. After a write, or when F = 0, the gap is 2 clocks.
- R11: Address, write data, direction, timings, float count and capture mode are fixed at acceptance. Input changes during an access do not affect it, and req_i is not accepted again until the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until ready_o |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Access address |
| wdata_i | input | DW | Write data |
| cfg_rd_i | input | 5*CW | Read timing fields |
| cfg_wr_i | input | 5*CW | Write timing fields |
| cfg_tdf_i | input | TDW | Float clocks after a read |
| cfg_rd_by_strb_i | input | 1 | Read capture edge: 1 = read strobe, 0 = chip select |
| ready_o | output | 1 | One-clock access completion |
| rdata_o | output | DW | Captured read data |
| ncs_o | output | 1 | Chip select, active low |
| nrd_o | output | 1 | Read strobe, active low |
| nwe_o | output | 1 | Write strobe, active low |
| addr_o | output | AW | Memory address |
| wdata_o | output | DW | Memory write data |
| data_oe_o | output | 1 | Write data drive enable |
| data_i | input | DW | Memory read data |

## Verification
A wrong cycle counter shows up at once at the pins. The strobe or chip-select edges move by a clock in the same access, and ready_o appears in the wrong cycle. The bench drives data_i with a value that changes every access cycle, so a capture on the wrong edge shows in rdata_o one clock after the access ends. A wrong float count or a stuck state shows as a late or early start of the following access, measured in clocks from the read's ready pulse.

// File: rtl/sm_pkg.sv
package sm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACC   = 2'd1,
    ST_FLOAT = 2'd2
  } acc_state_e;
endpackage

// File: rtl/sm_strobe_win.sv
module sm_strobe_win #(
  parameter int CW = 6
) (
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] setup_i,
  input  logic [CW-1:0] pulse_i,
  input  logic [CW-1:0] cyc_i,
  output logic          act_o,
  output logic          last_o,
  output logic          empty_o
);
  logic [CW:0] stop;
  logic [CW:0] cnt_x;

  assign stop    = {1'b0, setup_i} + {1'b0, pulse_i};
  assign cnt_x   = {1'b0, cnt_i};
  assign act_o   = (cnt_i >= setup_i) && (cnt_x < stop);
  // last low cycle: natural end of pulse, or cut at the cycle end
  assign last_o  = act_o && ((cnt_x + 1'b1 == stop) || (cnt_i == cyc_i - 1'b1));
  assign empty_o = (pulse_i == '0) || (setup_i >= cyc_i);
endmodule

// File: rtl/sm_access_seq.sv
module sm_access_seq
  import sm_pkg::*;
#(
  parameter int CW  = 6,
  parameter int TDW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           rd_i,
  input  logic [CW-1:0]  cyc_i,
  input  logic [TDW-1:0] tdf_i,
  output logic           idle_o,
  output logic           acc_o,
  output logic           flt_o,
  output logic           last_o,
  output logic [CW-1:0]  cnt_o
);
  acc_state_e     state_q;
  logic [CW-1:0]  cnt_q;
  logic [TDW-1:0] fcnt_q;

  assign idle_o = (state_q == ST_IDLE);
  assign acc_o  = (state_q == ST_ACC);
  assign flt_o  = (state_q == ST_FLOAT);
  assign last_o = acc_o && (cnt_q == cyc_i - 1'b1);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      fcnt_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_ACC;
          cnt_q   <= '0;
        end
        ST_ACC: begin
          if (last_o) begin
            cnt_q  <= '0;
            fcnt_q <= '0;
            state_q <= (rd_i && tdf_i != '0) ? ST_FLOAT : ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_FLOAT: begin
          if (fcnt_q == tdf_i - 1'b1) state_q <= ST_IDLE;
          fcnt_q <= fcnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sm_strobe_gen.sv
module sm_strobe_gen #(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int CW  = 6,
  parameter int TDW = 4,
  localparam int TW = 5 * CW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic           we_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [TW-1:0]  cfg_rd_i,
  input  logic [TW-1:0]  cfg_wr_i,
  input  logic [TDW-1:0] cfg_tdf_i,
  input  logic           cfg_rd_by_strb_i,
  output logic           ready_o,
  output logic [DW-1:0]  rdata_o,
  output logic           ncs_o,
  output logic           nrd_o,
  output logic           nwe_o,
  output logic [AW-1:0]  addr_o,
  output logic [DW-1:0]  wdata_o,
  output logic           data_oe_o,
  input  logic [DW-1:0]  data_i
);
  localparam int NWIN = 2;  // 0: data strobe, 1: chip select

  logic           idle, in_acc, in_float, last_cyc, accept;
  logic [CW-1:0]  cnt;
  logic [TW-1:0]  tim_q;
  logic [TDW-1:0] tdf_q;
  logic           we_q, mode_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q, rdata_q;
  logic [CW-1:0]  cyc_raw, cyc_eff;
  logic [NWIN-1:0] w_act, w_last, w_empty;
  logic           sel, cap;

  assign accept  = idle && req_i;
  assign cyc_raw = tim_q[4*CW +: CW];
  assign cyc_eff = (cyc_raw == '0) ? CW'(1) : cyc_raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tim_q   <= '0;
      tdf_q   <= '0;
      we_q    <= 1'b0;
      mode_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      tim_q   <= we_i ? cfg_wr_i : cfg_rd_i;
      tdf_q   <= cfg_tdf_i;
      we_q    <= we_i;
      mode_q  <= cfg_rd_by_strb_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  sm_access_seq #(.CW(CW), .TDW(TDW)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .rd_i    (!we_q),
    .cyc_i   (cyc_eff),
    .tdf_i   (tdf_q),
    .idle_o  (idle),
    .acc_o   (in_acc),
    .flt_o   (in_float),
    .last_o  (last_cyc),
    .cnt_o   (cnt)
  );

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    sm_strobe_win #(.CW(CW)) u_win (
      .cnt_i   (cnt),
      .setup_i (tim_q[g*CW +: CW]),
      .pulse_i (tim_q[(g+2)*CW +: CW]),
      .cyc_i   (cyc_eff),
      .act_o   (w_act[g]),
      .last_o  (w_last[g]),
      .empty_o (w_empty[g])
    );
  end

  assign sel = mode_q ? 1'b0 : 1'b1;
  assign cap = in_acc && !we_q && (w_empty[sel] ? last_cyc : w_last[sel]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (cap) rdata_q <= data_i;
  end

  assign ncs_o     = !(in_acc && w_act[1]);
  assign nrd_o     = !(in_acc && !we_q && w_act[0]);
  assign nwe_o     = !(in_acc && we_q && w_act[0]);
  assign data_oe_o = in_acc && we_q;
  assign ready_o   = last_cyc;
  assign rdata_o   = rdata_q;
  assign addr_o    = addr_q;
  assign wdata_o   = wdata_q;
endmodule

// File: rtl/sm_strobe_gen_chk.sv
module sm_strobe_gen_chk #(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ncs_o,
  input logic          nrd_o,
  input logic          nwe_o,
  input logic          data_oe_o,
  input logic          ready_o,
  input logic [AW-1:0] addr_o,
  input logic          in_acc_i,
  input logic          flt_i
);
  a_r7_ready_one_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
  a_r3_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!nrd_o && !nwe_o));
  a_r9_oe_covers_nwe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nwe_o |-> data_oe_o);
  a_r9_no_oe_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nrd_o |-> !data_oe_o);
  a_r10_float_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_i |-> (ncs_o && nrd_o && nwe_o && !data_oe_o && !ready_o));
  a_r11_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_acc_i && $past(in_acc_i) && !$past(ready_o)) |-> $stable(addr_o));
  a_r4_ready_in_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> in_acc_i);
  a_r2_cs_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_acc_i |-> ncs_o);
endmodule

bind sm_strobe_gen sm_strobe_gen_chk #(.AW(AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ncs_o     (ncs_o),
  .nrd_o     (nrd_o),
  .nwe_o     (nwe_o),
  .data_oe_o (data_oe_o),
  .ready_o   (ready_o),
  .addr_o    (addr_o),
  .in_acc_i  (in_acc),
  .flt_i     (in_float)
);

// File: tb/sm_strobe_gen_tb.sv
module sm_strobe_gen_tb;
  localparam int AW = 16, DW = 16, CW = 6, TDW = 4, TW = 5 * CW;

  logic clk_i = 1'b0;
  always #4 clk_i = ~clk_i;

  logic rst_ni, req_i, we_i, cfg_rd_by_strb_i;
  logic [AW-1:0] addr_i;
  logic [DW-1:0] wdata_i, data_i;
  logic [TW-1:0] cfg_rd_i, cfg_wr_i;
  logic [TDW-1:0] cfg_tdf_i;
  logic ready_o, ncs_o, nrd_o, nwe_o, data_oe_o;
  logic [DW-1:0] rdata_o, wdata_o;
  logic [AW-1:0] addr_o;

  int total = 0, bad = 0;

  sm_strobe_gen #(.AW(AW), .DW(DW), .CW(CW), .TDW(TDW)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .cfg_rd_i(cfg_rd_i), .cfg_wr_i(cfg_wr_i),
    .cfg_tdf_i(cfg_tdf_i), .cfg_rd_by_strb_i(cfg_rd_by_strb_i),
    .ready_o(ready_o), .rdata_o(rdata_o), .ncs_o(ncs_o), .nrd_o(nrd_o),
    .nwe_o(nwe_o), .addr_o(addr_o), .wdata_o(wdata_o), .data_oe_o(data_oe_o),
    .data_i(data_i)
  );

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", r, act, exp, $time);
    end
  endtask

  function automatic logic [TW-1:0] pack(int ss, int cs, int sp, int cp, int cy);
    logic [CW-1:0] a, b, c, d, e;
    a = CW'(ss); b = CW'(cs); c = CW'(sp); d = CW'(cp); e = CW'(cy);
    return {e, d, c, b, a};
  endfunction

  function automatic bit win(int s, int p, int k);
    return (k >= s) && (k < s + p);
  endfunction

  function automatic int cap_idx(int s, int p, int cyc);
    if (p == 0 || s >= cyc) return cyc - 1;
    return ((s + p) < cyc ? (s + p) : cyc) - 1;
  endfunction

  // one full access; returns at the negedge of the clock after the last access cycle
  task automatic run(input bit we, input bit mode, input int ss, input int cs, input int sp,
                     input int cp, input int cy, input int tdf, input bit wait_flt);
    logic [AW-1:0] a;
    logic [DW-1:0] wd, pat;
    int cyc, ci;
    a = AW'($urandom); wd = DW'($urandom); pat = DW'($urandom);
    @(negedge clk_i);
    req_i = 1'b1; we_i = we; addr_i = a; wdata_i = wd;
    cfg_tdf_i = TDW'(tdf); cfg_rd_by_strb_i = mode;
    if (we) begin cfg_wr_i = pack(ss, cs, sp, cp, cy); cfg_rd_i = TW'($urandom); end
    else    begin cfg_rd_i = pack(ss, cs, sp, cp, cy); cfg_wr_i = TW'($urandom); end
    cyc = (cy == 0) ? 1 : cy;
    ci  = mode ? cap_idx(ss, sp, cyc) : cap_idx(cs, cp, cyc);
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk_i);
      data_i = pat ^ DW'(k);
      if (k == 0) begin  // R11: inputs changed mid-access
        addr_i = ~a; wdata_i = ~wd; cfg_rd_i = TW'($urandom); cfg_wr_i = TW'($urandom);
        cfg_tdf_i = TDW'($urandom); cfg_rd_by_strb_i = ~mode;
      end
      check("R2 ncs", ncs_o, !win(cs, cp, k));
      check("R3 nrd", nrd_o, !(!we && win(ss, sp, k)));
      check("R3 nwe", nwe_o, !(we && win(ss, sp, k)));
      check("R7/R4 ready", ready_o, k == cyc - 1);
      check("R9 oe", data_oe_o, we);
      if (we) check("R9 wdata", wdata_o, wd);
      check("R11 addr", addr_o, a);
      if (k == cyc - 1) req_i = 1'b0;
    end
    @(negedge clk_i);
    check("R7 ready low", ready_o, 0);
    check("R9 oe off", data_oe_o, 0);
    check("R6 ncs off", ncs_o, 1);
    if (!we) check("R8 rdata", rdata_o, pat ^ DW'(ci));
    if (!we && wait_flt) repeat (tdf) @(negedge clk_i);
  endtask

  task automatic gap_test(input int tdf, input bit after_write);
    int n;
    run(after_write, 1'b1, 1, 0, 2, 3, 4, tdf, 1'b0);
    req_i = 1'b1; we_i = 1'b1; cfg_wr_i = pack(0, 0, 2, 3, 4); cfg_tdf_i = '0;
    n = 0;
    do begin @(negedge clk_i); n++; end while (!data_oe_o && n < 30);
    check("R10 gap", n, after_write ? 1 : tdf + 1);
    while (!ready_o) @(negedge clk_i);
    req_i = 1'b0;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd5417));
    rst_ni = 1'b0; req_i = 1'b0; we_i = 1'b0; addr_i = '0; wdata_i = '0; data_i = '0;
    cfg_rd_i = '0; cfg_wr_i = '0; cfg_tdf_i = '0; cfg_rd_by_strb_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R1 ncs", ncs_o, 1); check("R1 nrd", nrd_o, 1); check("R1 nwe", nwe_o, 1);
    check("R1 oe", data_oe_o, 0); check("R1 ready", ready_o, 0); check("R1 rdata", rdata_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 ncs idle", ncs_o, 1);

    // R4: separate lengths, write 4 and read 7
    run(1'b1, 1'b1, 0, 1, 2, 3, 4, 0, 1'b1);
    run(1'b0, 1'b1, 0, 1, 4, 4, 7, 0, 1'b1);
    // R5: zero setups
    run(1'b0, 1'b0, 0, 0, 3, 5, 5, 0, 1'b1);
    // R6: pulses past the cycle end
    run(1'b0, 1'b1, 2, 1, 9, 12, 5, 0, 1'b1);
    run(1'b1, 1'b1, 3, 0, 9, 9, 4, 0, 1'b1);
    // R4: cycle count 0 acts as 1
    run(1'b0, 1'b1, 0, 0, 1, 1, 0, 0, 1'b1);
    // R8: empty strobe window, chip-select mode, setup past cycle
    run(1'b0, 1'b1, 1, 0, 0, 4, 6, 0, 1'b1);
    run(1'b0, 1'b0, 0, 7, 2, 2, 5, 0, 1'b1);
    run(1'b0, 1'b0, 2, 0, 2, 6, 8, 0, 1'b1);
    // R10: float gaps
    gap_test(3, 1'b0);
    gap_test(0, 1'b0);
    gap_test(2, 1'b1);
    gap_test(15, 1'b0);

    for (int i = 0; i < 300; i++)
      run(1'($urandom), 1'($urandom), int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
          int'($urandom_range(0, 9)), int'($urandom_range(0, 9)), int'($urandom_range(0, 12)),
          int'($urandom_range(0, 3)), 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule